// File: doc/BRIEF.md
# Word-Addressed Data Memory with Range Error

This block is a small data memory with a single access port. In each cycle it either reads a word or writes a word. A read is combinational: the output follows the address as soon as the read request is present. A write takes effect only at the rising clock edge. The number of words is a parameter, and it does not need to be a power of two.

Every address is checked against that depth. If the address does not name an implemented word, the block raises an error flag during the request. The access then does nothing: the address is not folded onto a real word, no word is changed, and the output reads as zero. This lets surrounding control logic detect a bad pointer in the same cycle that it is presented.

An active-low asynchronous reset clears every word to zero. When read and write are requested together, the write is performed, and the output shows the contents from before the edge.

Top module: `dmem_top`

## Requirements
- R1: While reset is low and after it is released, every implemented word reads as zero until it is written.
- R2: With the read request high and an in-range address, the data output equals the word stored at that address in the same cycle, with no clock edge needed.
- R3: A write with an in-range address changes the stored word only at the rising clock edge. Before that edge a read of the same address returns the old value, and after the edge it returns the written value.
- R4: The error flag is high in any cycle where a read or a write is requested with an address greater than or equal to the depth.
- R5: The error flag is low whenever no request is present, even for an illegal address, and it is low for any request to a legal address.
- R6: A write to an out-of-range address leaves every implemented word unchanged. In particular, it does not alias onto the word selected by the low address bits.
- R7: A read from an out-of-range address drives the data output to zero.
- R8: When read and write are both requested to a legal address, the write is committed at the edge, and during that cycle the data output shows the contents from before the edge.
- R9: The data output is zero whenever the read request is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset that clears the array |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Data to be written |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request; wins over a read in the same cycle |
| rdata | output | DATA_W | Combinational read data, zero when not reading legally |
| err | output | 1 | High while a request uses an out-of-range address |

## Verification
The bench builds the block with a depth of 12 and a 4-bit address, so that addresses 12 to 15 are encodable but illegal. This lets it hit the first illegal address and the last legal one (11). It also gives out-of-range writes a real alias target in the low bits (12 folds onto 4, 15 onto 7), so R6 is tested by reading those aliases back. A 16-bit data width keeps the written patterns distinct.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    // Decoded per-cycle access decision
    typedef struct packed {
        logic we;   // commit a write at the next edge
        logic re;   // drive the stored word to the output
        logic err;  // illegal address under a request
    } dmem_ctl_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_BOTH  = 2'b11
    } dmem_op_e;

endpackage

// File: rtl/dmem_range.sv
module dmem_range #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_range
);
    localparam int unsigned CMP_W = ADDR_W + 1;
    localparam logic [CMP_W-1:0] LIMIT = CMP_W'(DEPTH);

    always_comb begin
        in_range = ({1'b0, addr} < LIMIT);
    end
endmodule

// File: rtl/dmem_ctl.sv
module dmem_ctl
    import dmem_pkg::*;
(
    input  logic      rd_en,
    input  logic      wr_en,
    input  logic      in_range,
    output dmem_ctl_t ctl
);
    dmem_op_e op;

    always_comb begin
        op  = dmem_op_e'({wr_en, rd_en});
        ctl = '0;
        unique case (op)
            OP_IDLE: ctl = '0;
            OP_READ: begin
                ctl.re  = in_range;
                ctl.err = !in_range;
            end
            OP_WRITE: begin
                ctl.we  = in_range;
                ctl.err = !in_range;
            end
            OP_BOTH: begin
                // write wins; the output still shows the pre-edge word
                ctl.we  = in_range;
                ctl.re  = in_range;
                ctl.err = !in_range;
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/dmem_store.sv
module dmem_store #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < int'(DEPTH); i++) begin
            mem_d[i] = mem_q[i];
            if (we && (int'(addr) == i)) begin
                mem_d[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < int'(DEPTH); i++) begin
            if (re && (int'(addr) == i)) begin
                rdata = mem_q[i];
            end
        end
    end
endmodule

// File: rtl/dmem_top.sv
module dmem_top
    import dmem_pkg::*;
#(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    input  logic              wr_en,
    output logic [DATA_W-1:0] rdata,
    output logic              err
);
    logic      in_range;
    dmem_ctl_t ctl;

    dmem_range #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_range (
        .addr     (addr),
        .in_range (in_range)
    );

    dmem_ctl u_ctl (
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .in_range (in_range),
        .ctl      (ctl)
    );

    dmem_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl.we),
        .re    (ctl.re),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata)
    );

    assign err = ctl.err;
endmodule

// File: rtl/dmem_chk.sv
module dmem_chk #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              rd_en,
    input logic              wr_en,
    input logic [DATA_W-1:0] rdata,
    input logic              err
);
    logic illegal;
    assign illegal = (int'(addr) >= int'(DEPTH));

    // R4
    oob_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && illegal) |-> err);

    // R5
    err_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ((rd_en || wr_en) && illegal));

    // R7
    oob_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && illegal) |-> (rdata == '0));

    // R9
    idle_out_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0));

    // R3
    write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && !$past(illegal) && rd_en && (addr == $past(addr)))
        |-> (rdata == $past(wdata)));

    // R2
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en) && $past(rd_en) && rd_en && !illegal
         && (addr == $past(addr))) |-> $stable(rdata));
endmodule

bind dmem_top dmem_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .wdata (wdata),
    .rd_en (rd_en),
    .wr_en (wr_en),
    .rdata (rdata),
    .err   (err)
);

// File: tb/dmem_top_test.sv
module dmem_top_test;
    localparam int unsigned DEPTH  = 12;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned DATA_W = 16;

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic [3:0]  a;
        logic [15:0] d;
        logic [15:0] exp_q;
        logic        exp_e;
    } vec_t;

    // applied in order, one per cycle, starting from a cleared array
    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 4'd3,  16'h1111, 16'h0000, 1'b0}, // R3 write
        '{1'b1, 1'b0, 4'd3,  16'h0000, 16'h1111, 1'b0}, // R2 R3
        '{1'b1, 1'b1, 4'd5,  16'h2222, 16'h0000, 1'b0}, // R8 pre-edge
        '{1'b1, 1'b0, 4'd5,  16'h0000, 16'h2222, 1'b0}, // R8 committed
        '{1'b0, 1'b1, 4'd12, 16'hDEAD, 16'h0000, 1'b1}, // R4 R6
        '{1'b1, 1'b0, 4'd12, 16'h0000, 16'h0000, 1'b1}, // R4 R7
        '{1'b0, 1'b1, 4'd15, 16'hBEEF, 16'h0000, 1'b1}, // R4 R6
        '{1'b1, 1'b0, 4'd4,  16'h0000, 16'h0000, 1'b0}, // R6 alias of 12
        '{1'b0, 1'b0, 4'd13, 16'h0000, 16'h0000, 1'b0}, // R5 R9
        '{1'b0, 1'b1, 4'd11, 16'h7777, 16'h0000, 1'b0}, // R5 top word
        '{1'b1, 1'b0, 4'd11, 16'h0000, 16'h7777, 1'b0}, // R2
        '{1'b1, 1'b0, 4'd3,  16'h0000, 16'h1111, 1'b0}, // R2 held
        '{1'b0, 1'b0, 4'd3,  16'h0000, 16'h0000, 1'b0}, // R9
        '{1'b1, 1'b1, 4'd3,  16'hABCD, 16'h1111, 1'b0}, // R8
        '{1'b1, 1'b0, 4'd3,  16'h0000, 16'hABCD, 1'b0}, // R8
        '{1'b1, 1'b0, 4'd7,  16'h0000, 16'h0000, 1'b0}, // R6 alias of 15
        '{1'b1, 1'b0, 4'd0,  16'h0000, 16'h0000, 1'b0}  // R1 untouched
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic              rd_en = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] rdata;
    logic              err;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dmem_top #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .wdata (wdata),
        .rd_en (rd_en),
        .wr_en (wr_en),
        .rdata (rdata),
        .err   (err)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic drive(input logic r, input logic w, input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        rd_en = r;
        wr_en = w;
        addr  = a;
        wdata = d;
        #1;
    endtask

    initial begin
        #400000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R1: during reset and after release every word is zero
        #1;
        rd_en = 1'b1;
        addr  = 4'd3;
        #1;
        check("R1 in reset", {16'h0, rdata}, 32'h0);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < int'(DEPTH); i++) begin
            drive(1'b1, 1'b0, 4'(i), 16'h0);
            check("R1 cleared", {16'h0, rdata}, 32'h0);
            check("R5 legal no err", {31'h0, err}, 32'h0);
        end

        // table walk
        for (int k = 0; k < NV; k++) begin
            drive(VEC[k].rd, VEC[k].wr, VEC[k].a, VEC[k].d);
            check("R2/R3/R6/R7/R8/R9 data", {16'h0, rdata}, {16'h0, VEC[k].exp_q});
            check("R4/R5 err", {31'h0, err}, {31'h0, VEC[k].exp_e});
        end

        // R3: write not visible until the edge, visible right after it
        drive(1'b1, 1'b1, 4'd2, 16'h5555);
        check("R3 before edge", {16'h0, rdata}, 32'h0);
        @(posedge clk);
        #1;
        check("R3 after edge", {16'h0, rdata}, 32'h5555);

        // R2: output follows address change with no edge
        drive(1'b1, 1'b0, 4'd5, 16'h0);
        check("R2 addr 5", {16'h0, rdata}, 32'h2222);
        addr = 4'd11;
        #1;
        check("R2 addr 11 same cycle", {16'h0, rdata}, 32'h7777);

        // R4: read of first illegal address while both requested
        drive(1'b1, 1'b1, 4'd12, 16'h9999);
        check("R4 both illegal err", {31'h0, err}, 32'h1);
        check("R7 both illegal data", {16'h0, rdata}, 32'h0);
        drive(1'b1, 1'b0, 4'd4, 16'h0);
        check("R6 alias after both", {16'h0, rdata}, 32'h0);

        // R1: reset mid-run clears written words
        @(negedge clk);
        rst_n = 1'b0;
        rd_en = 1'b0;
        wr_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 1'b0, 4'd3, 16'h0);
        check("R1 reset clears word 3", {16'h0, rdata}, 32'h0);
        drive(1'b1, 1'b0, 4'd11, 16'h0);
        check("R1 reset clears word 11", {16'h0, rdata}, 32'h0);

        drive(1'b0, 1'b0, 4'd0, 16'h0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule